// File: doc/BRIEF.md
# Branch Clock Gate Controller

This block decides whether one downstream branch clock is allowed to run. Software controls it through three small registers on a simple one-cycle write bus: a control/status register, a block-control register and a vote register. The branch runs when its own enable source is active or when any master holding a vote bit inside the branch's vote mask asks for it. The enable source is either a software enable bit or, when hardware control is selected, a request line driven by the bus fabric.

The control register also reports a four-bit status code. The code follows the effective enable only after a fixed synchronisation delay, so software can poll it to learn when a gate change has settled. The same register holds a post-divide value, with values above the configured maximum rejected. It also holds two retention requests, one for periphery state and one for memory state, which reach their outputs only while the branch reports halted. Writes that set a retention bit must not come in adjacent bus cycles; a violation raises a protocol-error pulse. A bit in the block-control register drives the block reset output while it is set.

Top module: `bcg_branch_ctrl`

## Requirements
- R1: After reset every register field is zero, the gate output is low, the status code reads 0x8 (halted), and the retention, error and block-reset outputs are low.
- R2: With hardware control off (control bit 1 = 0) and no active vote, the gate output equals control bit 0 one cycle after the write that set it.
- R3: With control bit 1 = 1, the gate output follows the hw_req input with one cycle of latency and control bit 0 has no effect on it.
- R4: The gate output is also high one cycle after any vote-register bit that is set in VOTE_MASK; vote bits outside the mask have no effect.
- R5: Control bits 31:28 read 0x8 when halted, 0x2 when running only because of hw_req under hardware control, and 0x0 when running for any other reason; no other code appears.
- R6: The status code reflects the enable conditions of the cycle before a clock edge only after SYNC_STAGES edges, and shows the previous code until then.
- R7: Control bits 24:16 hold the post-divide value, presented on div_o; a control write whose field exceeds MAX_DIV leaves the stored value unchanged while the other fields of that write still take effect.
- R8: Control bit 13 (periphery) and bit 14 (memory) are stored and read back; ret_periph_o and ret_mem_o are high only while the matching bit is set and the status reads 0x8.
- R9: proto_err_o pulses for one cycle after a control write with bit 13 or 14 set that directly follows, in the previous cycle, another such write; a gap of two cycles raises nothing.
- R10: Block-control bit 0 is stored, read back, and drives blk_rst_o from the cycle after the write for as long as it stays set.
- R11: The vote register holds NUM_VOTERS bits in its low bits, read back zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_wr | input | 1 | Register write strobe, one write per cycle |
| csr_sel | input | 2 | Register select: 0 control, 1 block control, 2 vote, 3 unused |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the selected register |
| hw_req | input | 1 | Fabric run request used under hardware control |
| branch_en_o | output | 1 | Gate enable for the branch clock |
| div_o | output | 9 | Accepted post-divide value |
| ret_periph_o | output | 1 | Periphery retention request while halted |
| ret_mem_o | output | 1 | Memory retention request while halted |
| blk_rst_o | output | 1 | Block reset, high while the reset bit is set |
| proto_err_o | output | 1 | One-cycle pulse on a retention spacing violation |

## Verification
A wrong enable-source or vote decode shows on branch_en_o one cycle after the offending write or hw_req change, while a wrong status code or synchroniser depth shows in bits 31:28 exactly SYNC_STAGES cycles later. A stored post-divide value that accepted an out-of-range write is visible on div_o and in readback on the next cycle. A broken spacing tracker either misses the proto_err_o pulse right after an adjacent pair or raises one after a legal two-cycle gap. Retention outputs leaking while running show up in the first cycle the status leaves 0x8.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  typedef enum logic [3:0] {
    ST_RUN    = 4'h0,
    ST_FABRIC = 4'h2,
    ST_HALT   = 4'h8
  } bcg_status_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_BLK  = 2'd1,
    SEL_VOTE = 2'd2,
    SEL_NONE = 2'd3
  } bcg_sel_e;

  localparam int SW_EN_BIT   = 0;
  localparam int HW_CTL_BIT  = 1;
  localparam int RET_PER_BIT = 13;
  localparam int RET_MEM_BIT = 14;
  localparam int DIV_LSB     = 16;
  localparam int DIV_W       = 9;
  localparam int STAT_LSB    = 28;

  function automatic logic [3:0] status_code(input logic on, input logic fabric);
    if (!on)        return ST_HALT;
    else if (fabric) return ST_FABRIC;
    else             return ST_RUN;
  endfunction

  function automatic logic div_ok(input logic [DIV_W-1:0] val, input int unsigned max_div);
    return 32'(val) <= max_div;
  endfunction

  function automatic logic [31:0] pack_ctrl(input logic [3:0] st, input logic [DIV_W-1:0] dv,
                                            input logic rm, input logic rp,
                                            input logic hw, input logic sw);
    logic [31:0] r;
    r = '0;
    r[STAT_LSB +: 4]       = st;
    r[DIV_LSB +: DIV_W]    = dv;
    r[RET_MEM_BIT]         = rm;
    r[RET_PER_BIT]         = rp;
    r[HW_CTL_BIT]          = hw;
    r[SW_EN_BIT]           = sw;
    return r;
  endfunction

endpackage

// File: rtl/bcg_regs.sv
module bcg_regs
  import bcg_pkg::*;
#(
  parameter int NUM_VOTERS = 4,
  parameter int MAX_DIV    = 200
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [1:0]            sel,
  input  logic [31:0]           wdata,
  output logic                  sw_en,
  output logic                  hw_ctl,
  output logic                  ret_per,
  output logic                  ret_mem,
  output logic [DIV_W-1:0]      div_q,
  output logic                  blk_q,
  output logic [NUM_VOTERS-1:0] vote_q,
  output logic                  proto_err
);

  logic wr_ctrl, wr_blk, wr_vote;
  logic ret_set_wr, recent_q, div_accept;
  logic [DIV_W-1:0] div_new;

  assign wr_ctrl    = wr && (sel == SEL_CTRL);
  assign wr_blk     = wr && (sel == SEL_BLK);
  assign wr_vote    = wr && (sel == SEL_VOTE);
  assign div_new    = wdata[DIV_LSB +: DIV_W];
  assign div_accept = div_ok(div_new, MAX_DIV);
  assign ret_set_wr = wr_ctrl && (wdata[RET_PER_BIT] || wdata[RET_MEM_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en     <= 1'b0;
      hw_ctl    <= 1'b0;
      ret_per   <= 1'b0;
      ret_mem   <= 1'b0;
      div_q     <= '0;
      blk_q     <= 1'b0;
      vote_q    <= '0;
      recent_q  <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sw_en   <= wdata[SW_EN_BIT];
        hw_ctl  <= wdata[HW_CTL_BIT];
        ret_per <= wdata[RET_PER_BIT];
        ret_mem <= wdata[RET_MEM_BIT];
        if (div_accept) div_q <= div_new;
      end
      if (wr_blk)  blk_q  <= wdata[0];
      if (wr_vote) vote_q <= wdata[NUM_VOTERS-1:0];
      recent_q  <= ret_set_wr;
      proto_err <= ret_set_wr && recent_q;
    end
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(div_q) <= MAX_DIV); // R7

  AST_DIV_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !div_accept) |=> $stable(div_q)); // R7

  AST_ERR_AFTER_RET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(ret_set_wr)); // R9

endmodule

// File: rtl/bcg_status.sv
module bcg_status
  import bcg_pkg::*;
#(
  parameter int SYNC_STAGES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       on,
  input  logic [3:0] code,
  output logic       branch_en,
  output logic [3:0] status
);

  logic [3:0] pipe_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      branch_en <= 1'b0;
      for (int i = 0; i < SYNC_STAGES; i++) pipe_q[i] <= ST_HALT;
    end else begin
      branch_en <= on;
      pipe_q[0] <= code;
      for (int i = 1; i < SYNC_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign status = pipe_q[SYNC_STAGES-1];

  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_HALT) || (status == ST_RUN) || (status == ST_FABRIC)); // R5

endmodule

// File: rtl/bcg_branch_ctrl.sv
module bcg_branch_ctrl
  import bcg_pkg::*;
#(
  parameter int                  NUM_VOTERS  = 4,
  parameter logic [NUM_VOTERS-1:0] VOTE_MASK = 4'b0101,
  parameter int                  MAX_DIV     = 200,
  parameter int                  SYNC_STAGES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr,
  input  logic [1:0]  csr_sel,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        hw_req,
  output logic        branch_en_o,
  output logic [8:0]  div_o,
  output logic        ret_periph_o,
  output logic        ret_mem_o,
  output logic        blk_rst_o,
  output logic        proto_err_o
);

  logic                  sw_en, hw_ctl, ret_per, ret_mem, blk_q;
  logic [DIV_W-1:0]      div_q;
  logic [NUM_VOTERS-1:0] vote_q;
  logic                  vote_hit, src_on, eff_on, fabric_on;
  logic [3:0]            code, status;
  logic                  halted;

  bcg_regs #(.NUM_VOTERS(NUM_VOTERS), .MAX_DIV(MAX_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(csr_wr), .sel(csr_sel), .wdata(csr_wdata),
    .sw_en(sw_en), .hw_ctl(hw_ctl), .ret_per(ret_per), .ret_mem(ret_mem),
    .div_q(div_q), .blk_q(blk_q), .vote_q(vote_q), .proto_err(proto_err_o)
  );

  assign vote_hit  = |(vote_q & VOTE_MASK);
  assign src_on    = hw_ctl ? hw_req : sw_en;
  assign eff_on    = src_on || vote_hit;
  assign fabric_on = hw_ctl && hw_req && !vote_hit;
  assign code      = status_code(eff_on, fabric_on);

  bcg_status #(.SYNC_STAGES(SYNC_STAGES)) u_status (
    .clk(clk), .rst_n(rst_n), .on(eff_on), .code(code),
    .branch_en(branch_en_o), .status(status)
  );

  assign halted       = (status == ST_HALT);
  assign ret_periph_o = ret_per && halted;
  assign ret_mem_o    = ret_mem && halted;
  assign blk_rst_o    = blk_q;
  assign div_o        = div_q;

  always_comb begin
    unique case (csr_sel)
      SEL_CTRL: csr_rdata = pack_ctrl(status, div_q, ret_mem, ret_per, hw_ctl, sw_en);
      SEL_BLK:  csr_rdata = {31'd0, blk_q};
      SEL_VOTE: csr_rdata = 32'(vote_q);
      default:  csr_rdata = '0;
    endcase
  end

  AST_RET_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_periph_o || ret_mem_o) |-> (status == ST_HALT)); // R8

  AST_SW_BIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_ctl && !hw_req && !vote_hit) |=> !branch_en_o); // R3

endmodule

// File: tb/bcg_branch_ctrl_test.sv
module bcg_branch_ctrl_test;

  localparam int NV    = 4;
  localparam logic [NV-1:0] MASK = 4'b0101;
  localparam int MAXD  = 200;
  localparam int SYNC  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [1:0]  csr_sel = 2'd0;
  logic [31:0] csr_wdata = '0;
  logic        hw_req = 1'b0;
  logic [31:0] csr_rdata;
  logic        branch_en_o, ret_periph_o, ret_mem_o, blk_rst_o, proto_err_o;
  logic [8:0]  div_o;

  int tests = 0, fails = 0;
  bit done = 0;

  // bench model state
  logic m_sw, m_hw, m_rp, m_rm, m_blk, m_last, m_err, m_bren;
  logic [8:0] m_div;
  logic [NV-1:0] m_vote;
  logic [3:0] m_pipe [SYNC];
  string br_tag;

  always #5 clk = ~clk;

  bcg_branch_ctrl #(.NUM_VOTERS(NV), .VOTE_MASK(MASK), .MAX_DIV(MAXD), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .hw_req(hw_req), .branch_en_o(branch_en_o), .div_o(div_o),
    .ret_periph_o(ret_periph_o), .ret_mem_o(ret_mem_o), .blk_rst_o(blk_rst_o),
    .proto_err_o(proto_err_o)
  );

  function automatic logic exp_on(input logic h);
    return (m_hw ? h : m_sw) || (|(m_vote & MASK));
  endfunction

  function automatic logic [3:0] exp_code(input logic h);
    if (!exp_on(h)) return 4'h8;
    if (m_hw && h && !(|(m_vote & MASK))) return 4'h2;
    return 4'h0;
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [1:0] s);
    logic [31:0] r;
    r = '0;
    case (s)
      2'd0: begin
        r[31:28] = m_pipe[SYNC-1];
        r[24:16] = m_div;
        r[14] = m_rm; r[13] = m_rp; r[1] = m_hw; r[0] = m_sw;
      end
      2'd1: r[0] = m_blk;
      2'd2: r[NV-1:0] = m_vote;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [1:0] s, input logic [31:0] d, input logic h);
    logic rs;
    @(negedge clk);
    csr_wr = w; csr_sel = s; csr_wdata = d; hw_req = h;
    for (int i = SYNC-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
    m_pipe[0] = exp_code(h);
    m_bren = exp_on(h);
    br_tag = m_hw ? "R3" : ((|(m_vote & MASK)) ? "R4" : "R2");
    rs = w && (s == 2'd0) && (d[13] || d[14]);
    m_err = rs && m_last;
    m_last = rs;
    if (w && s == 2'd0) begin
      m_sw = d[0]; m_hw = d[1]; m_rp = d[13]; m_rm = d[14];
      if (d[24:16] <= MAXD) m_div = d[24:16];
    end
    if (w && s == 2'd1) m_blk = d[0];
    if (w && s == 2'd2) m_vote = d[NV-1:0];
    @(posedge clk);
    #2;
    check(br_tag, 32'(branch_en_o), 32'(m_bren));
    check("R6", 32'(csr_rdata[31:28] & {4{s == 2'd0}}), 32'(m_pipe[SYNC-1] & {4{s == 2'd0}}));
    check("R5", 32'((m_pipe[SYNC-1] == 4'h0) || (m_pipe[SYNC-1] == 4'h2) || (m_pipe[SYNC-1] == 4'h8)), 32'd1);
    check(s == 2'd1 ? "R10" : (s == 2'd2 ? "R11" : "R7"), csr_rdata, exp_rdata(s));
    check("R7", 32'(div_o), 32'(m_div));
    check("R8", {30'd0, ret_mem_o, ret_periph_o},
          {30'd0, m_rm && m_pipe[SYNC-1] == 4'h8, m_rp && m_pipe[SYNC-1] == 4'h8});
    check("R9", 32'(proto_err_o), 32'(m_err));
    check("R10", 32'(blk_rst_o), 32'(m_blk));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned r;
    logic [31:0] d;
    r = $urandom(32'd4242);
    m_sw = 0; m_hw = 0; m_rp = 0; m_rm = 0; m_blk = 0; m_last = 0; m_err = 0; m_bren = 0;
    m_div = '0; m_vote = '0;
    for (int i = 0; i < SYNC; i++) m_pipe[i] = 4'h8;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1", csr_rdata, 32'h8000_0000);
    check("R1", {27'd0, branch_en_o, ret_periph_o, ret_mem_o, blk_rst_o, proto_err_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 software enable and R6 status lag
    step(1, 2'd0, 32'h0000_0001, 0);
    repeat (4) step(0, 2'd0, 0, 0);
    step(1, 2'd0, 32'h0000_0000, 0);
    repeat (4) step(0, 2'd0, 0, 0);
    // R3 hardware control, software bit ignored, fabric status code
    step(1, 2'd0, 32'h0000_0003, 0);
    repeat (2) step(0, 2'd0, 0, 0);
    repeat (4) step(0, 2'd0, 0, 1);
    repeat (4) step(0, 2'd0, 0, 0);
    // R4 vote outside mask ignored, inside mask enables
    step(1, 2'd2, 32'h0000_000A, 0);
    repeat (4) step(0, 2'd0, 0, 0);
    step(1, 2'd2, 32'h0000_0004, 1);
    repeat (4) step(0, 2'd0, 0, 1);
    step(1, 2'd2, 32'h0, 0);
    // R7 divider limit
    step(1, 2'd0, 32'(MAXD) << 16, 0);
    step(1, 2'd0, (32'(MAXD + 1) << 16) | 32'h1, 0);
    // R9 adjacent retention writes, then legal gap
    step(1, 2'd0, 32'h0000_2000, 0);
    step(1, 2'd0, 32'h0000_4000, 0);
    step(0, 2'd0, 0, 0);
    step(1, 2'd0, 32'h0000_6000, 0);
    repeat (4) step(0, 2'd0, 0, 0);
    // R10 block reset
    step(1, 2'd1, 32'h1, 0);
    step(0, 2'd1, 0, 0);
    step(1, 2'd1, 32'h0, 0);

    for (int n = 0; n < 3000; n++) begin
      d = $urandom;
      if ($urandom_range(0, 1) == 0) d[24:16] = 9'($urandom_range(0, 255));
      if ($urandom_range(0, 3) != 0) d[14:13] = 2'b00;
      step($urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)), d, 1'($urandom_range(0, 1)));
    end
    finish_run();
  end

endmodule